// File: doc/BRIEF.md
# Angle PWM Frame Encoder

This block turns a 12-bit angle and a fault flag into a pulse-width-modulated line that a host can decode with a timer capture. Time is counted in PWM periods. A PWM period is a programmable number of system clocks, made by a prescaler. Each frame lasts exactly 4119 PWM periods and has four sections, always in the same order:

- a 12-period lead-in, always high;
- a 4-period status section, high when there is no fault;
- a 4095-period payload section, high for as many periods as the angle value;
- an 8-period trailer, always low.

A reported fault blanks both the status and the payload sections. The frame then shows only the 12-period lead-in.

The angle and the fault flag are captured once, at the first PWM period of each frame, so a frame never changes part-way through. An enable input gates the whole encoder. A route input chooses which of two output pins carries the line; the other pin stays low.

Control is a five-state sequencer, stepped only on prescaler ticks:

- IDLE goes to INIT on the first tick while enabled; the inputs are captured here.
- INIT goes to FLAG after 12 periods.
- FLAG goes to DATA after 4 periods.
- DATA goes to TAIL after 4095 periods.
- TAIL goes back to INIT after 8 periods, capturing again.
- Every state falls back to IDLE when the enable drops.

The output pins are registered, one system clock behind the sequencer.

Top module: `angle_pwm_encoder`

## Requirements
- R1: While enabled, consecutive frames start exactly 4119 PWM periods apart.
- R2: One PWM period lasts `tick_div`+1 system clock cycles, where `tick_div` is the unsigned value on that port.
- R3: With `fault_in`=0 captured, the selected pin is high for one unbroken run of 12+4+A PWM periods from the frame start, where A (0 to 4095) is the captured angle, and is low for the rest of the frame.
- R4: With `fault_in`=1 captured, the selected pin is high for exactly the first 12 PWM periods of the frame, and low for the rest of the frame.
- R5: Angle and fault are sampled only at the clock edge that starts a frame. A change that arrives one clock later has no effect until the following frame.
- R6: `route_sel`=0 drives the line on `pwm_w` and holds `pwm_i` low; `route_sel`=1 drives it on `pwm_i` and holds `pwm_w` low.
- R7: From the clock after `pwm_en` falls, both pins are low. Once `pwm_en` rises again, a full frame starts within two system clocks when `tick_div`=0.
- R8: While `rst_n` is low, both pins are low and the sequencer is in IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_en | input | 1 | Encoder enable; low forces IDLE and both pins low |
| route_sel | input | 1 | 0: line on `pwm_w`; 1: line on `pwm_i` |
| tick_div | input | 8 | Prescaler divisor minus one |
| angle_in | input | 12 | Angle to encode; captured at each frame start |
| fault_in | input | 1 | 1 reports a fault; captured at each frame start |
| pwm_w | output | 1 | First candidate output pin |
| pwm_i | output | 1 | Second candidate output pin |

## Verification
The two functions that can fall into the same clock are the frame-boundary capture and a change of the angle on `angle_in`.

The bench measures one frame to find its start edge. It then counts 4119 clocks forward with the prescaler at zero and changes the angle once on the clock just before the next boundary capture, and once on the clock right after it.

In the first case the very next frame must carry the new value. In the second case the next frame must keep the old value and only the frame after it must show the new one. Each verdict is read off the length of the high run on the selected pin.

// File: rtl/apfe_pkg.sv
package apfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_FLAG = 3'd2,
        ST_DATA = 3'd3,
        ST_TAIL = 3'd4
    } sect_e;

endpackage

// File: rtl/apfe_prescaler.sv
module apfe_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [PRESC_W-1:0] div_i,
    output logic               tick_o
);

    logic [PRESC_W-1:0] pc_q;

    assign tick_o = en_i && (pc_q >= div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!en_i || tick_o) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // R2
    pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && $stable(div_i)) |-> (pc_q <= div_i));

endmodule

// File: rtl/apfe_sequencer.sv
module apfe_sequencer
    import apfe_pkg::*;
#(
    parameter int ANGLE_W  = 12,
    parameter int INIT_LEN = 12,
    parameter int FLAG_LEN = 4,
    parameter int DATA_LEN = 4095,
    parameter int TAIL_LEN = 8,
    parameter int SEC_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               tick_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               err_i,
    output sect_e              state_o,
    output logic [SEC_W-1:0]   cnt_o,
    output logic [ANGLE_W-1:0] ang_o,
    output logic               err_o
);

    sect_e              state_q, state_d;
    logic [SEC_W-1:0]   cnt_q, cnt_d;
    logic [ANGLE_W-1:0] ang_q;
    logic               err_q;
    logic               start_fr;

    localparam logic [SEC_W-1:0] INIT_LAST = SEC_W'(INIT_LEN - 1);
    localparam logic [SEC_W-1:0] FLAG_LAST = SEC_W'(FLAG_LEN - 1);
    localparam logic [SEC_W-1:0] DATA_LAST = SEC_W'(DATA_LEN - 1);
    localparam logic [SEC_W-1:0] TAIL_LAST = SEC_W'(TAIL_LEN - 1);

    // next-state and section counter
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        start_fr = 1'b0;
        if (!en_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (tick_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d  = ST_INIT;
                    cnt_d    = '0;
                    start_fr = 1'b1;
                end
                ST_INIT: begin
                    if (cnt_q == INIT_LAST) begin
                        state_d = ST_FLAG;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_FLAG: begin
                    if (cnt_q == FLAG_LAST) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt_q == DATA_LAST) begin
                        state_d = ST_TAIL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt_q == TAIL_LAST) begin
                        state_d  = ST_INIT;
                        cnt_d    = '0;
                        start_fr = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // frame-boundary capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ang_q <= '0;
            err_q <= 1'b0;
        end else if (start_fr) begin
            ang_q <= angle_i;
            err_q <= err_i;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign ang_o   = ang_q;
    assign err_o   = err_q;

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_fr |=> ($stable(ang_q) && $stable(err_q)));

    // R7
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_IDLE));

    // R2
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && (state_q != $past(state_q))) |-> $past(tick_i));

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_INIT) && ($past(state_q) == ST_TAIL)) |-> ($past(cnt_q) == TAIL_LAST));

    // R3
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && ($past(state_q) != ST_DATA)) |-> ($past(state_q) == ST_FLAG));

endmodule

// File: rtl/apfe_pin_router.sv
module apfe_pin_router
    import apfe_pkg::*;
#(
    parameter int ANGLE_W = 12,
    parameter int SEC_W   = 12,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               sel_i,
    input  sect_e              state_i,
    input  logic [SEC_W-1:0]   cnt_i,
    input  logic [ANGLE_W-1:0] ang_i,
    input  logic               err_i,
    output logic               pwm_w_o,
    output logic               pwm_i_o
);

    localparam int CMP_W = (SEC_W > ANGLE_W) ? SEC_W : ANGLE_W;

    logic line;

    // output decode per state
    always_comb begin
        unique case (state_i)
            ST_IDLE: line = 1'b0;
            ST_INIT: line = 1'b1;
            ST_FLAG: line = !err_i;
            ST_DATA: line = !err_i && (CMP_W'(cnt_i) < CMP_W'(ang_i));
            ST_TAIL: line = 1'b0;
            default: line = 1'b0;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            logic w_q, i_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    w_q <= 1'b0;
                    i_q <= 1'b0;
                end else begin
                    w_q <= en_i && !sel_i && line;
                    i_q <= en_i &&  sel_i && line;
                end
            end
            assign pwm_w_o = w_q;
            assign pwm_i_o = i_q;

            // R7
            off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !en_i |=> (!pwm_w_o && !pwm_i_o));

            // R4
            err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (err_i && ((state_i == ST_FLAG) || (state_i == ST_DATA))) |=> (!pwm_w_o && !pwm_i_o));
        end else begin : g_comb
            assign pwm_w_o = en_i && !sel_i && line;
            assign pwm_i_o = en_i &&  sel_i && line;
        end
    endgenerate

    // R6
    one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pwm_w_o, pwm_i_o}));

endmodule

// File: rtl/angle_pwm_encoder.sv
module angle_pwm_encoder
    import apfe_pkg::*;
#(
    parameter int ANGLE_W  = 12,
    parameter int PRESC_W  = 8,
    parameter int INIT_LEN = 12,
    parameter int FLAG_LEN = 4,
    parameter int DATA_LEN = 4095,
    parameter int TAIL_LEN = 8,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwm_en,
    input  logic               route_sel,
    input  logic [PRESC_W-1:0] tick_div,
    input  logic [ANGLE_W-1:0] angle_in,
    input  logic               fault_in,
    output logic               pwm_w,
    output logic               pwm_i
);

    localparam int MAX_AB  = (INIT_LEN > FLAG_LEN) ? INIT_LEN : FLAG_LEN;
    localparam int MAX_CD  = (DATA_LEN > TAIL_LEN) ? DATA_LEN : TAIL_LEN;
    localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int SEC_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic               tick;
    sect_e              state;
    logic [SEC_W-1:0]   sec_cnt;
    logic [ANGLE_W-1:0] ang_l;
    logic               err_l;

    apfe_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (pwm_en),
        .div_i  (tick_div),
        .tick_o (tick)
    );

    apfe_sequencer #(
        .ANGLE_W  (ANGLE_W),
        .INIT_LEN (INIT_LEN),
        .FLAG_LEN (FLAG_LEN),
        .DATA_LEN (DATA_LEN),
        .TAIL_LEN (TAIL_LEN),
        .SEC_W    (SEC_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (pwm_en),
        .tick_i  (tick),
        .angle_i (angle_in),
        .err_i   (fault_in),
        .state_o (state),
        .cnt_o   (sec_cnt),
        .ang_o   (ang_l),
        .err_o   (err_l)
    );

    apfe_pin_router #(
        .ANGLE_W (ANGLE_W),
        .SEC_W   (SEC_W),
        .OUT_REG (OUT_REG)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (pwm_en),
        .sel_i   (route_sel),
        .state_i (state),
        .cnt_i   (sec_cnt),
        .ang_i   (ang_l),
        .err_i   (err_l),
        .pwm_w_o (pwm_w),
        .pwm_i_o (pwm_i)
    );

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> ((state == ST_IDLE) && !pwm_w && !pwm_i));

endmodule

// File: tb/angle_pwm_encoder_tb.sv
module angle_pwm_encoder_tb;

    localparam int FRAME = 4119;
    localparam int NV    = 7;
    // {sel, fault, div[7:0], angle[11:0], expected high periods[12:0]}
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'd0, 12'd0,    13'd16},
        {1'b0, 1'b0, 8'd0, 12'd1,    13'd17},
        {1'b1, 1'b0, 8'd0, 12'd2047, 13'd2063},
        {1'b1, 1'b0, 8'd0, 12'd4095, 13'd4111},
        {1'b0, 1'b1, 8'd0, 12'd3000, 13'd12},
        {1'b1, 1'b1, 8'd0, 12'd4095, 13'd12},
        {1'b0, 1'b0, 8'd2, 12'd500,  13'd516}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_en = 1'b0;
    logic        route_sel = 1'b0;
    logic [7:0]  tick_div = 8'd0;
    logic [11:0] angle_in = 12'd0;
    logic        fault_in = 1'b0;
    logic        pwm_w, pwm_i;
    logic        act;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign act = pwm_w | pwm_i;

    always #5 clk = ~clk;

    angle_pwm_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_en    (pwm_en),
        .route_sel (route_sel),
        .tick_div  (tick_div),
        .angle_in  (angle_in),
        .fault_in  (fault_in),
        .pwm_w     (pwm_w),
        .pwm_i     (pwm_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // wait for the next rising edge of the combined line (frame start)
    task automatic wait_start(output bit ok);
        bit prev;
        prev = act;
        ok = 1'b0;
        for (int g = 0; g < 40000; g++) begin
            @(negedge clk);
            if (act && !prev) begin
                ok = 1'b1;
                break;
            end
            prev = act;
        end
    endtask

    // called at the first high sample of a frame; returns at the next frame start
    task automatic measure(input bit sel, output int hi, output int per, output int other);
        bit prev, run, sp, op;
        hi = 0; per = 0; other = 0; run = 1'b1;
        prev = 1'b0;
        for (int g = 0; g < 40000; g++) begin
            if (g > 0 && act && !prev) break;
            per++;
            sp = sel ? pwm_i : pwm_w;
            op = sel ? pwm_w : pwm_i;
            if (op) other++;
            if (sp && run) hi++;
            else if (!sp) run = 1'b0;
            prev = act;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R1 watchdog expired: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        bit ok;
        int hi, per, oth, k;

        // R8: reset holds pins low even with enable high
        pwm_en = 1'b1;
        repeat (4) @(negedge clk);
        check(!pwm_w && !pwm_i, "R8", "pins during reset", int'(act), 0);
        pwm_en = 1'b0;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!pwm_w && !pwm_i, "R7", "pins while disabled", int'(act), 0);

        // R7: start-up latency with div 0
        angle_in = 12'd10;
        pwm_en = 1'b1;
        k = 0;
        while (!act && k < 10) begin
            @(negedge clk);
            k++;
        end
        check(k == 2, "R7", "clocks to first rise", k, 2);
        measure(1'b0, hi, per, oth);
        check(hi == 26, "R3", "first frame high", hi, 26);
        check(per == FRAME, "R1", "first frame period", per, FRAME);

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            int d, eh;
            string rq;
            route_sel = VEC[v][34];
            fault_in  = VEC[v][33];
            tick_div  = VEC[v][32:25];
            angle_in  = VEC[v][24:13];
            eh        = int'(VEC[v][12:0]);
            d         = int'(VEC[v][32:25]) + 1;
            rq        = VEC[v][33] ? "R4" : "R3";
            wait_start(ok);
            check(ok, "R1", "frame start seen", int'(ok), 1);
            measure(VEC[v][34], hi, per, oth);
            check(hi == eh * d, rq, "high run", hi, eh * d);
            check(per == FRAME * d, (d > 1) ? "R2" : "R1", "frame period", per, FRAME * d);
            check(oth == 0, "R6", "unselected pin high count", oth, 0);
        end

        // restore fast prescaler, align to a frame start
        tick_div = 8'd0;
        route_sel = 1'b0;
        fault_in = 1'b0;
        angle_in = 12'd100;
        wait_start(ok);
        measure(1'b0, hi, per, oth);

        // R5: change arriving just in time for the boundary capture
        repeat (FRAME - 2) @(posedge clk);
        @(negedge clk);
        angle_in = 12'd777;
        wait_start(ok);
        measure(1'b0, hi, per, oth);
        check(hi == 793, "R5", "in-time capture high", hi, 793);

        // R5: change arriving one clock after the capture
        repeat (FRAME - 1) @(posedge clk);
        @(negedge clk);
        angle_in = 12'd1234;
        fault_in = 1'b1;
        wait_start(ok);
        measure(1'b0, hi, per, oth);
        check(hi == 793, "R5", "late change ignored", hi, 793);
        measure(1'b0, hi, per, oth);
        check(hi == 12, "R5", "late change in next frame", hi, 12);

        // R7: disable mid-frame
        fault_in = 1'b0;
        angle_in = 12'd300;
        repeat (100) @(negedge clk);
        pwm_en = 1'b0;
        k = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (act) k++;
        end
        check(k == 0, "R7", "high samples while disabled", k, 0);
        pwm_en = 1'b1;
        k = 0;
        while (!act && k < 10) begin
            @(negedge clk);
            k++;
        end
        check(k == 2, "R7", "clocks to rise after re-enable", k, 2);
        measure(1'b0, hi, per, oth);
        check(hi == 316, "R3", "high after re-enable", hi, 316);
        check(per == FRAME, "R1", "period after re-enable", per, FRAME);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule